// File: doc/BRIEF.md
# Dual Masked Alarm Comparator

This block keeps two programmable time-of-day alarms and checks them against the clock-calendar values each time the time-keeping core signals its once-per-second update. The first alarm compares seconds, minutes, hours and a day-or-date byte. The second alarm compares minutes, hours and a day-or-date byte, and is only tested when the seconds value is zero. Each alarm byte carries its own mask bit in bit 7. A masked field is left out of the comparison, so the same hardware gives repeat rates from every second (or every minute) up to a full day or date match.

A match sets a sticky flag for that alarm. The flag stays set until the host writes a zero to it through the register write port. Each flag drives an active-low interrupt level when its enable bit is set. A routing bit selects one of two modes. In the first, each alarm has its own output. In the second, both alarms share the first output.

The register map uses 4-bit addresses, with the alarm bytes at fixed addresses. Alarm one occupies addresses 7 to 10 (seconds, minutes, hours, day/date). Alarm two occupies addresses 11 to 13 (minutes, hours, day/date). Control is at address 14 and status at address 15.

Top module: `dual_alarm_cmp`

## Requirements
- R1: While `rst` is high, both flags clear, the control bits clear and both `irq_a_n` and `irq_b_n` read 1. The alarm bytes reset to 0.
- R2: Alarm one's flag (`flag1`) is set only on a clock edge where `tick` is 1 and every unmasked field of alarm one matches. When `tick` is 0, a matching time leaves the flag unchanged. The flag is visible in the cycle after that edge.
- R3: Bit 7 of any alarm byte is a mask: when it is 1, that field is excluded. With all four bytes of alarm one masked, every tick sets `flag1`.
- R4: In a day/date byte (addresses 10 and 13), bit 6 selects the reference. A value of 0 compares bits 5:0 with `now_date[5:0]`, and a value of 1 compares them with `now_day[5:0]`.
- R5: The hours comparison uses bits 6:0. This includes bit 6 (the 12-hour mode bit) and bit 5 (PM or tens of hours), so hours that differ only in bit 5 do not match. The seconds and minutes comparisons also use bits 6:0.
- R6: Alarm two (address 11 minutes, 12 hours, 13 day/date) ignores seconds. Its flag `flag2` can be set only on a tick where `now_sec[6:0]` is 0.
- R7: The status register is at address 15, with bit 0 for `flag1` and bit 1 for `flag2`. Writing a 0 to a bit clears that flag, and writing a 1 leaves it unchanged. Flags otherwise stay set. A match on the same edge as a clear leaves the flag set.
- R8: The control register is at address 14, with bit 0 enabling alarm one and bit 1 enabling alarm two. In separate mode (bit 2 = 0), `irq_a_n` is 0 exactly when `flag1` and its enable are 1. Likewise, `irq_b_n` is 0 exactly when `flag2` and its enable are 1.
- R9: In shared mode (control bit 2 = 1), `irq_a_n` is 0 when either enabled flag is set, and `irq_b_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Once-per-second update strobe from the time-keeping core |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours with mode and PM bits |
| now_day | input | 8 | Current day of week |
| now_date | input | 8 | Current date of month, BCD |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 4 | Host register address |
| wr_data | input | 8 | Host register write data |
| flag1 | output | 1 | Sticky alarm-one flag |
| flag2 | output | 1 | Sticky alarm-two flag |
| irq_a_n | output | 1 | Active-low interrupt, alarm one or shared |
| irq_b_n | output | 1 | Active-low interrupt, alarm two in separate mode |

## Verification
The assertions assume that the time inputs are stable on any edge where `tick` is high. They also assume that a flag can only rise through a tick, so they take the tick strobe as the sole source of new matches. They treat host writes as arbitrary, including a clear that collides with a tick. The stimulus follows these rules: it changes time inputs and strobes only on the falling edge, and holds each tick for exactly one cycle. It also deliberately places one status clear on the same edge as a matching tick.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    typedef logic [7:0] byte_t;

    typedef struct packed {
        byte_t sec;
        byte_t min;
        byte_t hour;
        byte_t dd;
    } alarm_set_t;

    typedef struct packed {
        byte_t sec;
        byte_t min;
        byte_t hour;
        byte_t day;
        byte_t date;
    } clock_now_t;

    typedef struct packed {
        logic shared;
        logic en2;
        logic en1;
    } irq_ctrl_t;

    localparam byte_t TIME_CARE = 8'h7F;

    // bit 7 masks the field; otherwise compare the cared bits
    function automatic logic field_hit(byte_t al, byte_t now, byte_t care);
        return al[7] || ((al & care) == (now & care));
    endfunction

    // bit 6 picks day-of-week (1) or date (0); bits 5:0 compared
    function automatic logic dd_hit(byte_t al, byte_t day, byte_t date);
        byte_t ref_v;
        ref_v = al[6] ? day : date;
        return al[7] || (al[5:0] == ref_v[5:0]);
    endfunction

endpackage

// File: rtl/alarm_match.sv
module alarm_match
    import alarm_pkg::*;
#(
    parameter bit USE_SEC = 1'b1
) (
    input  alarm_set_t al,
    input  clock_now_t now,
    output logic       hit
);
    logic sec_ok;

    generate
        if (USE_SEC) begin : g_sec_cmp
            assign sec_ok = field_hit(al.sec, now.sec, TIME_CARE);
        end else begin : g_on_minute
            // R6: second alarm only tested at the top of the minute
            assign sec_ok = (now.sec[6:0] == 7'd0);
        end
    endgenerate

    assign hit = sec_ok
              && field_hit(al.min,  now.min,  TIME_CARE)
              && field_hit(al.hour, now.hour, TIME_CARE)
              && dd_hit(al.dd, now.day, now.date);
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
    import alarm_pkg::*;
#(
    parameter int AW        = 4,
    parameter int A1_BASE   = 7,
    parameter int A2_BASE   = 11,
    parameter int CTRL_ADDR = 14,
    parameter int STAT_ADDR = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  byte_t         wr_data,
    input  logic          hit1,
    input  logic          hit2,
    output alarm_set_t    al1,
    output alarm_set_t    al2,
    output irq_ctrl_t     ctrl,
    output logic          flag1,
    output logic          flag2
);
    localparam int A1_BYTES = 4;
    localparam int A2_BYTES = 3;

    byte_t a1_q [A1_BYTES];
    byte_t a2_q [A2_BYTES];

    generate
        for (genvar i = 0; i < A1_BYTES; i++) begin : g_a1
            always_ff @(posedge clk) begin
                if (rst)
                    a1_q[i] <= '0;
                else if (wr_en && wr_addr == AW'(A1_BASE + i))
                    a1_q[i] <= wr_data;
            end
        end
        for (genvar j = 0; j < A2_BYTES; j++) begin : g_a2
            always_ff @(posedge clk) begin
                if (rst)
                    a2_q[j] <= '0;
                else if (wr_en && wr_addr == AW'(A2_BASE + j))
                    a2_q[j] <= wr_data;
            end
        end
    endgenerate

    assign al1 = '{sec: a1_q[0], min: a1_q[1], hour: a1_q[2], dd: a1_q[3]};
    assign al2 = '{sec: 8'h80,   min: a2_q[0], hour: a2_q[1], dd: a2_q[2]};

    logic stat_wr, ctrl_wr;
    assign stat_wr = wr_en && (wr_addr == AW'(STAT_ADDR));
    assign ctrl_wr = wr_en && (wr_addr == AW'(CTRL_ADDR));

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (ctrl_wr)
            ctrl <= '{shared: wr_data[2], en2: wr_data[1], en1: wr_data[0]};
    end

    // sticky flags: clear by writing 0, a same-edge match wins
    always_ff @(posedge clk) begin
        if (rst) begin
            flag1 <= 1'b0;
            flag2 <= 1'b0;
        end else begin
            flag1 <= (tick && hit1) || (flag1 && !(stat_wr && !wr_data[0]));
            flag2 <= (tick && hit2) || (flag2 && !(stat_wr && !wr_data[1]));
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!flag1 && !flag2 && ctrl == '0));

    p_flag_needs_tick_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(flag1) || $rose(flag2)) |-> $past(tick));

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flag1 && !(wr_en && wr_addr == AW'(STAT_ADDR) && !wr_data[0])) |=> flag1);

    p_flag2_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flag2 && !(wr_en && wr_addr == AW'(STAT_ADDR) && !wr_data[1])) |=> flag2);
endmodule

// File: rtl/irq_route.sv
module irq_route
    import alarm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  irq_ctrl_t ctrl,
    input  logic      flag1,
    input  logic      flag2,
    output logic      irq_a_n,
    output logic      irq_b_n
);
    logic act1, act2;
    assign act1 = ctrl.en1 && flag1;
    assign act2 = ctrl.en2 && flag2;

    always_comb begin
        if (ctrl.shared) begin
            irq_a_n = !(act1 || act2);
            irq_b_n = 1'b1;
        end else begin
            irq_a_n = !act1;
            irq_b_n = !act2;
        end
    end

    p_int_a_r8: assert property (@(posedge clk) disable iff (rst)
        (flag1 && ctrl.en1) |-> !irq_a_n);

    p_no_irq_unflagged_r8: assert property (@(posedge clk) disable iff (rst)
        (!flag1 && !flag2) |-> (irq_a_n && irq_b_n));

    p_shared_b_high_r9: assert property (@(posedge clk) disable iff (rst)
        (ctrl.shared && flag2 && ctrl.en2) |-> (!irq_a_n && irq_b_n));
endmodule

// File: rtl/dual_alarm_cmp.sv
module dual_alarm_cmp
    import alarm_pkg::*;
#(
    parameter int AW        = 4,
    parameter int A1_BASE   = 7,
    parameter int A2_BASE   = 11,
    parameter int CTRL_ADDR = 14,
    parameter int STAT_ADDR = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [7:0]    now_sec,
    input  logic [7:0]    now_min,
    input  logic [7:0]    now_hour,
    input  logic [7:0]    now_day,
    input  logic [7:0]    now_date,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output logic          flag1,
    output logic          flag2,
    output logic          irq_a_n,
    output logic          irq_b_n
);
    clock_now_t now;
    alarm_set_t al1, al2;
    irq_ctrl_t  ctrl;
    logic       hit1, hit2;

    assign now = '{sec: now_sec, min: now_min, hour: now_hour,
                   day: now_day, date: now_date};

    alarm_match #(.USE_SEC(1'b1)) u_m1 (.al(al1), .now(now), .hit(hit1));
    alarm_match #(.USE_SEC(1'b0)) u_m2 (.al(al2), .now(now), .hit(hit2));

    alarm_regs #(
        .AW(AW), .A1_BASE(A1_BASE), .A2_BASE(A2_BASE),
        .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
    ) u_regs (
        .clk(clk), .rst(rst), .tick(tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hit1(hit1), .hit2(hit2),
        .al1(al1), .al2(al2), .ctrl(ctrl),
        .flag1(flag1), .flag2(flag2)
    );

    irq_route u_route (
        .clk(clk), .rst(rst), .ctrl(ctrl),
        .flag1(flag1), .flag2(flag2),
        .irq_a_n(irq_a_n), .irq_b_n(irq_b_n)
    );

    p_a2_on_minute_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(flag2) |-> $past(now_sec[6:0] == 7'd0));
endmodule

// File: tb/tb_dual_alarm_cmp.sv
module tb_dual_alarm_cmp;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] now_sec = 0, now_min = 0, now_hour = 0, now_day = 1, now_date = 1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic       flag1, flag2, irq_a_n, irq_b_n;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_alarm_cmp dut (
        .clk(clk), .rst(rst), .tick(tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_day(now_day), .now_date(now_date),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .flag1(flag1), .flag2(flag2), .irq_a_n(irq_a_n), .irq_b_n(irq_b_n)
    );

    // behavioural reference model
    int  ma1 [4];
    int  ma2 [3];
    bit  men1, men2, mshr, mf1, mf2;

    function automatic bit fld(int al, int nw);
        return ((al & 128) != 0) || ((al & 127) == (nw & 127));
    endfunction
    function automatic bit ddm(int al, int dy, int dt);
        if ((al & 128) != 0) return 1;
        if ((al & 64) != 0) return (al & 63) == (dy & 63);
        return (al & 63) == (dt & 63);
    endfunction

    always @(posedge clk) begin
        bit h1, h2;
        if (rst) begin
            foreach (ma1[i]) ma1[i] = 0;
            foreach (ma2[i]) ma2[i] = 0;
            {men1, men2, mshr, mf1, mf2} = '0;
        end else begin
            h1 = tick && fld(ma1[0], now_sec) && fld(ma1[1], now_min)
                 && fld(ma1[2], now_hour) && ddm(ma1[3], now_day, now_date);
            h2 = tick && ((now_sec & 127) == 0) && fld(ma2[0], now_min)
                 && fld(ma2[1], now_hour) && ddm(ma2[2], now_day, now_date);
            if (wr_en) begin
                if (wr_addr >= 7 && wr_addr <= 10) ma1[wr_addr-7] = wr_data;
                else if (wr_addr >= 11 && wr_addr <= 13) ma2[wr_addr-11] = wr_data;
                else if (wr_addr == 14) begin
                    men1 = wr_data[0]; men2 = wr_data[1]; mshr = wr_data[2];
                end else if (wr_addr == 15) begin
                    if (!wr_data[0]) mf1 = 0;
                    if (!wr_data[1]) mf2 = 0;
                end
            end
            if (h1) mf1 = 1;
            if (h2) mf2 = 1;
        end
    end

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 flag1 model", flag1, mf1);
            chk("R6 flag2 model", flag2, mf2);
            chk("R8 irq_a_n model", irq_a_n,
                !((men1 && mf1) || (mshr && men2 && mf2)));
            chk("R9 irq_b_n model", irq_b_n, !(!mshr && men2 && mf2));
        end
    end

    task automatic wr(int a, int d);
        wr_en = 1; wr_addr = 4'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic set_now(int s, int m, int h, int dy, int dt);
        now_sec = 8'(s); now_min = 8'(m); now_hour = 8'(h);
        now_day = 8'(dy); now_date = 8'(dt);
    endtask

    task automatic tk(int s, int m, int h, int dy, int dt);
        set_now(s, m, h, dy, dt);
        tick = 1;
        @(negedge clk);
        tick = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 flag1 after reset", flag1, 0);
        chk("R1 flag2 after reset", flag2, 0);
        chk("R1 irq_a_n after reset", irq_a_n, 1);
        chk("R1 irq_b_n after reset", irq_b_n, 1);

        // R2 full match, separate mode, both enabled
        wr(14, 3);
        wr(7, 8'h30); wr(8, 8'h15); wr(9, 8'h08); wr(10, 8'h12);
        set_now(8'h30, 8'h15, 8'h08, 3, 8'h12);
        @(negedge clk);
        chk("R2 no flag without tick", flag1, 0);
        tk(8'h30, 8'h15, 8'h08, 3, 8'h12);
        chk("R2 flag1 on full match", flag1, 1);
        chk("R8 irq_a_n on flag1", irq_a_n, 0);
        chk("R8 irq_b_n idle", irq_b_n, 1);

        // R7 clear flag1 only
        wr(15, 8'h02);
        chk("R7 flag1 cleared", flag1, 0);
        tk(8'h31, 8'h15, 8'h08, 3, 8'h12);
        chk("R2 mismatch seconds no flag", flag1, 0);

        // R3 masked seconds
        wr(7, 8'h80);
        tk(8'h45, 8'h15, 8'h08, 3, 8'h12);
        chk("R3 masked seconds match", flag1, 1);
        wr(15, 0);
        wr(8, 8'h80); wr(9, 8'h80); wr(10, 8'h80);
        tk(8'h12, 8'h34, 8'h21, 6, 8'h27);
        chk("R3 all masked every tick", flag1, 1);
        wr(15, 0);

        // R4 day versus date
        wr(10, 8'h45);
        tk(8'h01, 8'h02, 8'h03, 5, 8'h09);
        chk("R4 day-of-week match", flag1, 1);
        wr(15, 0);
        tk(8'h01, 8'h02, 8'h03, 4, 8'h05);
        chk("R4 date ignored when day selected", flag1, 0);
        wr(10, 8'h05);
        tk(8'h01, 8'h02, 8'h03, 4, 8'h05);
        chk("R4 date match", flag1, 1);
        wr(15, 0);

        // R5 hours with 12-hour and PM bits
        wr(10, 8'h80); wr(9, 8'h68);
        tk(8'h00, 8'h00, 8'h48, 1, 1);
        chk("R5 AM does not match PM", flag1, 0);
        tk(8'h00, 8'h00, 8'h68, 1, 1);
        chk("R5 PM match", flag1, 1);
        wr(15, 0);

        // R6 second alarm at top of minute only
        wr(7, 8'h59); wr(9, 8'h80);
        wr(11, 8'h10); wr(12, 8'h80); wr(13, 8'h80);
        tk(8'h05, 8'h10, 8'h02, 2, 2);
        chk("R6 no flag2 off minute", flag2, 0);
        tk(8'h00, 8'h10, 8'h02, 2, 2);
        chk("R6 flag2 at seconds zero", flag2, 1);
        chk("R8 irq_b_n on flag2", irq_b_n, 0);
        chk("R8 irq_a_n idle", irq_a_n, 1);

        // R9 shared routing
        wr(14, 7);
        chk("R9 shared irq_a_n", irq_a_n, 0);
        chk("R9 shared irq_b_n high", irq_b_n, 1);
        wr(14, 5);
        chk("R8 disabled alarm two no irq", irq_a_n, 1);
        chk("R8 flag2 kept when disabled", flag2, 1);

        // R7 clear colliding with a match
        wr_en = 1; wr_addr = 15; wr_data = 0;
        set_now(8'h00, 8'h10, 8'h02, 2, 2); tick = 1;
        @(negedge clk);
        wr_en = 0; tick = 0;
        chk("R7 match wins over clear", flag2, 1);
        wr(15, 8'h01);
        chk("R7 flag2 cleared by bit1 zero", flag2, 0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule